// File: doc/BRIEF.md
# Image Sensor Line Readout Sequencer

This block drives the readout of a CMOS pixel array. After a start pulse it runs one frame as a series of line captures. Each line goes through four phases in a fixed order: pre-charge, exposure, correlated double sampling (CDS) and pixel readout. During CDS the block raises two separate sample strobes. The first captures the pixel's reset level and the second captures its signal level. The analog side subtracts the two samples.

There are two scan modes. Serial scan visits every row of the array in order and reads every column of each row, one pixel per clock. Random access handles a single row and a single column taken from address inputs. It adds a line-select step before pre-charge and a pixel-select step before the one-pixel readout. A frame-valid strobe works as vertical sync and a line-valid strobe works as horizontal sync. Row and column addresses go to the array decoders, and a pixel-valid strobe marks each column address that is being read.

The phase lengths, the array width and height, the scan mode and the random-access address are inputs. They are captured when a frame starts and held until it ends.

Top module: `img_readout_seq`

## Requirements
- R1: After reset the block is idle. `phase_o` is 0, `busy_o`, every strobe and `done_o` are low, and both addresses are 0.
- R2: `phase_o` encodes the phase as idle=0, line-select=1, pre-charge=2, exposure=3, CDS=4, pixel-select=5, readout=6, done=7. A serial line shows pre-charge for max(P,1) cycles, then exposure for max(X,1) cycles, then CDS for C+2 cycles, then readout for W cycles. P, X and C are the latched phase-length inputs.
- R3: In serial scan the rows run 0..H-1 in order and each row is one line. In readout the column address steps 0..W-1, one per clock. A width or height of 0 acts as 1. The row address holds for the whole line.
- R4: In random access the frame is: line-select (1 cycle), pre-charge, exposure, CDS, pixel-select (1 cycle), readout (1 cycle), done. The row address equals the latched row select throughout. The column address equals the latched column select in the pixel-select and readout cycles.
- R5: `line_en_o` and `pix_valid_o` are high exactly in readout cycles. Outside pixel-select and readout the column address is 0.
- R6: `frame_en_o` is high in every readout cycle. In serial scan it is also high in the pre-charge, exposure and CDS cycles of rows 1..H-1. It is low at all other times.
- R7: `rst_smp_o` is high only in the first CDS cycle and `sig_smp_o` is high only in the last CDS cycle. The two strobes are never high together.
- R8: `done_o` is high for exactly one cycle, directly after the final readout cycle, and the block is idle on the next cycle. `busy_o` is high from the cycle after an accepted start through the done cycle.
- R9: A start pulse is accepted only when the block is idle. A start pulse while busy has no effect on the sequence.
- R10: The mode, phase lengths, width, height and select addresses are sampled on the accepted start. Changing these inputs during a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start pulse |
| rand_mode_i | input | 1 | 1 selects random access, 0 selects serial scan |
| pre_len_i | input | LEN_W | Pre-charge cycles |
| exp_len_i | input | LEN_W | Exposure cycles |
| cds_len_i | input | LEN_W | CDS settle cycles between the two samples |
| width_i | input | COL_W | Columns per line |
| height_i | input | ROW_W | Lines per frame |
| sel_row_i | input | ROW_W | Row for random access |
| sel_col_i | input | COL_W | Column for random access |
| phase_o | output | 3 | Current phase code |
| busy_o | output | 1 | Frame in progress |
| frame_en_o | output | 1 | Vertical sync / frame valid |
| line_en_o | output | 1 | Horizontal sync / line valid |
| pix_valid_o | output | 1 | Pixel address valid |
| row_addr_o | output | ROW_W | Row address |
| col_addr_o | output | COL_W | Column address |
| rst_smp_o | output | 1 | Reset-level sample strobe |
| sig_smp_o | output | 1 | Signal-level sample strobe |
| done_o | output | 1 | End-of-frame pulse |

## Verification
The assertions assume that the configuration registers stay constant for the whole of a frame. They also assume the serial-scan column address never reaches the latched width. Both assumptions hold only because the configuration is latched at start.

The stimulus deliberately breaks the condition those registers shield. Right after each accepted start it drives the configuration and mode inputs to unrelated values, and it pulses start at varying points inside frames. An expected value that came from the live inputs would therefore be wrong.

The sweep covers zero and non-zero phase lengths, zero width and height, and both scan modes with several select addresses.

// File: rtl/img_seq_pkg.sv
package img_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LSEL = 3'd1,
    PH_PRE  = 3'd2,
    PH_EXP  = 3'd3,
    PH_CDS  = 3'd4,
    PH_PSEL = 3'd5,
    PH_READ = 3'd6,
    PH_DONE = 3'd7
  } phase_e;
endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] len_i,
  output logic          first_o,
  output logic          last_o
);
  logic [TW-1:0] cnt_q;

  assign first_o = (cnt_q == '0);
  assign last_o  = (len_i == '0) || (cnt_q == len_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + TW'(1);
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && len_i != '0) |-> (cnt_q < len_i));
endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_init_i,
  input  logic             row_inc_i,
  input  logic             col_run_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        row_q <= '0;
    else if (load_i)    row_q <= row_init_i;
    else if (row_inc_i) row_q <= row_q + ROW_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        col_q <= '0;
    else if (col_run_i) col_q <= col_q + COL_W'(1);
    else                col_q <= '0;
  end

  assign row_o = row_q;
  assign col_o = col_q;

  // R3
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_inc_i && !load_i) |=> (row_o == $past(row_o) + ROW_W'(1)));
endmodule

// File: rtl/img_readout_seq.sv
module img_readout_seq
  import img_seq_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rand_mode_i,
  input  logic [LEN_W-1:0] pre_len_i,
  input  logic [LEN_W-1:0] exp_len_i,
  input  logic [LEN_W-1:0] cds_len_i,
  input  logic [COL_W-1:0] width_i,
  input  logic [ROW_W-1:0] height_i,
  input  logic [ROW_W-1:0] sel_row_i,
  input  logic [COL_W-1:0] sel_col_i,
  output logic [2:0]       phase_o,
  output logic             busy_o,
  output logic             frame_en_o,
  output logic             line_en_o,
  output logic             pix_valid_o,
  output logic [ROW_W-1:0] row_addr_o,
  output logic [COL_W-1:0] col_addr_o,
  output logic             rst_smp_o,
  output logic             sig_smp_o,
  output logic             done_o
);
  localparam int TW = ((LEN_W > COL_W) ? LEN_W : COL_W) + 2;

  phase_e           phase_q, phase_d;
  logic             rand_q;
  logic [LEN_W-1:0] pre_q, exp_q, cds_q;
  logic [COL_W-1:0] w_q, sel_col_q;
  logic [ROW_W-1:0] h_q;
  logic [TW-1:0]    len;
  logic             start_ok, first, last, row_last, row_inc, col_run;
  logic [ROW_W-1:0] row_q, row_init;
  logic [COL_W-1:0] col_q;

  assign start_ok = start_i && (phase_q == PH_IDLE);

  // frame configuration, frozen for the whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rand_q    <= 1'b0;
      pre_q     <= '0;
      exp_q     <= '0;
      cds_q     <= '0;
      w_q       <= COL_W'(1);
      h_q       <= ROW_W'(1);
      sel_col_q <= '0;
    end else if (start_ok) begin
      rand_q    <= rand_mode_i;
      pre_q     <= pre_len_i;
      exp_q     <= exp_len_i;
      cds_q     <= cds_len_i;
      w_q       <= (width_i == '0) ? COL_W'(1) : width_i;
      h_q       <= (height_i == '0) ? ROW_W'(1) : height_i;
      sel_col_q <= sel_col_i;
    end
  end

  always_comb begin
    len = TW'(1);
    unique case (phase_q)
      PH_PRE:  len = (pre_q == '0) ? TW'(1) : TW'(pre_q);
      PH_EXP:  len = (exp_q == '0) ? TW'(1) : TW'(exp_q);
      PH_CDS:  len = TW'(cds_q) + TW'(2);
      PH_READ: len = rand_q ? TW'(1) : TW'(w_q);
      default: len = TW'(1);
    endcase
  end

  seq_phase_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (phase_q != PH_IDLE),
    .len_i   (len),
    .first_o (first),
    .last_o  (last)
  );

  assign row_last = (row_q == h_q - ROW_W'(1));

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = rand_mode_i ? PH_LSEL : PH_PRE;
      PH_LSEL: phase_d = PH_PRE;
      PH_PRE:  if (last) phase_d = PH_EXP;
      PH_EXP:  if (last) phase_d = PH_CDS;
      PH_CDS:  if (last) phase_d = rand_q ? PH_PSEL : PH_READ;
      PH_PSEL: phase_d = PH_READ;
      PH_READ: if (last) phase_d = (rand_q || row_last) ? PH_DONE : PH_PRE;
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign row_init = rand_mode_i ? sel_row_i : '0;
  assign row_inc  = (phase_q == PH_READ) && last && !rand_q && !row_last;
  assign col_run  = (phase_q == PH_READ) && !rand_q && !last;

  seq_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_ok),
    .row_init_i (row_init),
    .row_inc_i  (row_inc),
    .col_run_i  (col_run),
    .row_o      (row_q),
    .col_o      (col_q)
  );

  logic in_line;
  assign in_line = (phase_q == PH_PRE) || (phase_q == PH_EXP) || (phase_q == PH_CDS);

  assign phase_o     = phase_q;
  assign busy_o      = (phase_q != PH_IDLE);
  assign line_en_o   = (phase_q == PH_READ);
  assign pix_valid_o = (phase_q == PH_READ);
  assign frame_en_o  = (phase_q == PH_READ) || (!rand_q && in_line && row_q != '0);
  assign row_addr_o  = (phase_q == PH_IDLE) ? '0 : row_q;
  assign rst_smp_o   = (phase_q == PH_CDS) && first;
  assign sig_smp_o   = (phase_q == PH_CDS) && last;
  assign done_o      = (phase_q == PH_DONE);

  always_comb begin
    col_addr_o = '0;
    if (phase_q == PH_PSEL)      col_addr_o = sel_col_q;
    else if (phase_q == PH_READ) col_addr_o = rand_q ? sel_col_q : col_q;
  end

  // R2
  pre_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRE) |=> (phase_q == PH_PRE || phase_q == PH_EXP));
  // R2
  exp_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXP) |=> (phase_q == PH_EXP || phase_q == PH_CDS));
  // R3
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !rand_q && col_addr_o != w_q - COL_W'(1))
      |=> (pix_valid_o && col_addr_o == $past(col_addr_o) + COL_W'(1)));
  // R3
  col_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (rand_q || col_addr_o < w_q));
  // R6
  line_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_en_o |-> frame_en_o);
  // R7
  cds_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_smp_o && sig_smp_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(w_q) && $stable(h_q) && $stable(rand_q)));
endmodule

// File: tb/img_readout_seq_bench.sv
`timescale 1ns/1ps
module img_readout_seq_bench;
  localparam int ROW_W = 8;
  localparam int COL_W = 8;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             rand_mode_i = 1'b0;
  logic [LEN_W-1:0] pre_len_i = '0, exp_len_i = '0, cds_len_i = '0;
  logic [COL_W-1:0] width_i = '0, sel_col_i = '0;
  logic [ROW_W-1:0] height_i = '0, sel_row_i = '0;
  logic [2:0]       phase_o;
  logic             busy_o, frame_en_o, line_en_o, pix_valid_o;
  logic [ROW_W-1:0] row_addr_o;
  logic [COL_W-1:0] col_addr_o;
  logic             rst_smp_o, sig_smp_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int inj_at  = -1;
  string rc_tag = "R3";

  always #2 clk = ~clk;

  img_readout_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W)) u_img_readout_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .rand_mode_i(rand_mode_i),
    .pre_len_i(pre_len_i), .exp_len_i(exp_len_i), .cds_len_i(cds_len_i),
    .width_i(width_i), .height_i(height_i), .sel_row_i(sel_row_i), .sel_col_i(sel_col_i),
    .phase_o(phase_o), .busy_o(busy_o), .frame_en_o(frame_en_o), .line_en_o(line_en_o),
    .pix_valid_o(pix_valid_o), .row_addr_o(row_addr_o), .col_addr_o(col_addr_o),
    .rst_smp_o(rst_smp_o), .sig_smp_o(sig_smp_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // compare one cycle against the model, then step to the next negedge
  task automatic expc(input int ph, input int row, input int col, input bit fe,
                      input bit rs, input bit ss);
    chk("R2/R9/R10 phase", int'(phase_o), ph);
    chk({rc_tag, " row"}, int'(row_addr_o), row);
    chk({rc_tag, " col"}, int'(col_addr_o), col);
    chk("R5 line_en", int'(line_en_o), int'(ph == 6));
    chk("R5 pix_valid", int'(pix_valid_o), int'(ph == 6));
    chk("R6 frame_en", int'(frame_en_o), int'(fe));
    chk("R7 rst_smp", int'(rst_smp_o), int'(rs));
    chk("R7 sig_smp", int'(sig_smp_o), int'(ss));
    chk("R8 done", int'(done_o), int'(ph == 7));
    chk("R8 busy", int'(busy_o), int'(ph != 0));
    start_i = (cyc == inj_at);
    cyc++;
    @(negedge clk);
  endtask

  task automatic launch(input bit rnd, input int p, input int x, input int c,
                        input int w, input int h, input int sr, input int sc);
    @(negedge clk);
    rand_mode_i = rnd;
    pre_len_i = LEN_W'(p); exp_len_i = LEN_W'(x); cds_len_i = LEN_W'(c);
    width_i = COL_W'(w); height_i = ROW_W'(h);
    sel_row_i = ROW_W'(sr); sel_col_i = COL_W'(sc);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R10: scramble inputs after the accepted start
    rand_mode_i = ~rnd;
    pre_len_i = 8'd9; exp_len_i = 8'd7; cds_len_i = 8'd5;
    width_i = 8'd6; height_i = 8'd4; sel_row_i = 8'd33; sel_col_i = 8'd44;
    cyc = 0;
  endtask

  task automatic line_phases(input int row, input bit fe, input int p, input int x, input int c);
    int pp = (p == 0) ? 1 : p;
    int xx = (x == 0) ? 1 : x;
    for (int i = 0; i < pp; i++) expc(2, row, 0, fe, 0, 0);
    for (int i = 0; i < xx; i++) expc(3, row, 0, fe, 0, 0);
    for (int i = 0; i < c + 2; i++) expc(4, row, 0, fe, i == 0, i == c + 1);
  endtask

  task automatic idle_after();
    start_i = 1'b0;
    chk("R8 idle after done", int'(phase_o), 0);
    chk("R9 no restart from mid-frame start", int'(busy_o), 0);
  endtask

  task automatic serial_frame(input int p, input int x, input int c, input int w, input int h, input int inj);
    int ww = (w == 0) ? 1 : w;
    int hh = (h == 0) ? 1 : h;
    rc_tag = "R3";
    inj_at = inj;
    launch(1'b0, p, x, c, w, h, 3, 3);
    for (int r = 0; r < hh; r++) begin
      line_phases(r, r != 0, p, x, c);
      for (int k = 0; k < ww; k++) expc(6, r, k, 1, 0, 0);
    end
    expc(7, hh - 1, 0, 0, 0, 0);
    idle_after();
  endtask

  task automatic random_frame(input int p, input int x, input int c, input int sr, input int sc, input int inj);
    rc_tag = "R4";
    inj_at = inj;
    launch(1'b1, p, x, c, 5, 3, sr, sc);
    expc(1, sr, 0, 0, 0, 0);
    line_phases(sr, 0, p, x, c);
    expc(5, sr, sc, 0, 0, 0);
    expc(6, sr, sc, 1, 0, 0);
    expc(7, sr, 0, 0, 0, 0);
    idle_after();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int nf = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset phase", int'(phase_o), 0);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset strobes", int'({frame_en_o, line_en_o, pix_valid_o, rst_smp_o, sig_smp_o, done_o}), 0);
    chk("R1 reset row", int'(row_addr_o), 0);
    chk("R1 reset col", int'(col_addr_o), 0);

    for (int w = 0; w <= 3; w++)
      for (int h = 0; h <= 2; h++)
        for (int p = 0; p <= 2; p++)
          for (int x = 1; x <= 2; x++)
            for (int c = 0; c <= 1; c++) begin
              serial_frame(p, x, c, w, h, nf % 11);
              nf++;
            end

    for (int sr = 0; sr <= 10; sr += 5)
      for (int sc = 0; sc <= 7; sc += 7)
        for (int p = 0; p <= 2; p++)
          for (int x = 0; x <= 2; x++)
            for (int c = 0; c <= 1; c++) begin
              random_frame(p, x, c, sr, sc, nf % 9);
              nf++;
            end

    // wider serial line back to back with a random frame
    serial_frame(1, 3, 2, 9, 3, 20);
    random_frame(4, 1, 3, 200, 255, 4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule